// File: doc/BRIEF.md
# Dual Prescaler Timer Tick Generator

This block creates the count-enable strobes for a bank of five timer channels. All of them are derived from one fast reference clock, nominally 24 MHz. Two shared 8-bit prescalers divide the reference first. The lower channel group, channels 0 and 1, takes its rate from the first prescaler. The upper group, channels 2, 3 and 4, takes its rate from the second prescaler. Each channel then applies its own power-of-two divider. The output for each channel is a strobe one reference cycle wide. The counting channel that consumes the strobe advances once per strobe.

Configuration comes from two words delivered over a plain write port. Word select 0 is the prescaler word. Its low byte is the lower-group prescaler and its next byte is the upper-group prescaler. Word select 1 is the divider word, which holds one 4-bit select field per channel. The port carries only the 20 low bits of each word, because nothing above them is used. A write to either word restarts every prescaler and divider counter from zero. Because of this, the first interval after a write is already a full interval at the new rate.

Top module: `dual_psc_tick_gen`

## Requirements
- R1: After reset all tick outputs are low. The prescaler word resets to 0x0101, so both prescaler values are 1. The divider word resets to 0, so every channel divides by 1 and ticks every 2 cycles.
- R2: For a channel with prescaler value P and effective divider select s, the tick period is N = (P+1)·2^s reference cycles. Counting the restart edge as edge 0, the tick is high in the cycle after edges N, 2N, 3N and so on.
- R3: Bits 7:0 of the prescaler word (word select 0) set the prescaler used by channels 0 and 1.
- R4: Bits 15:8 of the prescaler word set the prescaler used by channels 2, 3 and 4.
- R5: The divider select for channel c is bits 4c+3:4c of the divider word (word select 1).
- R6: A divider select above 4 acts as 4, which is divide by 16.
- R7: A write to either word restarts all counters at the write edge. Every tick is low in the cycle after that edge, and timing resumes as in R2 with the write edge as edge 0.
- R8: Each tick is a single-cycle strobe whenever N > 1. It is high in every cycle only when N = 1.
- R9: A prescaler value of 0 passes every reference cycle to the divider stage. With P = 0 and s = 0 the tick is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_sel | input | 1 | Word select: 0 = prescaler word, 1 = divider word |
| cfg_wdata | input | 20 | Low bits of the configuration word being written |
| tick | output | 5 | One tick strobe per channel, bit c = channel c |

## Verification
Each tick comes out of a register fed by the divider's terminal condition, which itself depends on the prescaler's terminal condition. So a channel's strobe is visible in the cycle after the N-th rising edge counted from the last restart, where the reset release or the write edge is edge 0. The bench keeps one edge counter that it zeroes on every write edge. It samples all five outputs on each falling edge and compares them with (count > 0 and count mod N = 0). Every cycle after a write, including the first one, is checked against that rule. This also covers the quiet cycle of R7.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
  // configuration word selector on the write port
  typedef enum logic {
    CFG_WORD_PSC = 1'b0,
    CFG_WORD_DIV = 1'b1
  } cfg_word_e;
endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs
  import tick_gen_pkg::*;
#(
  parameter int unsigned NUM_CH  = 5,
  parameter int unsigned PSC_W   = 8,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned MAX_LOG = 4,
  parameter int unsigned LOG_W   = 3,
  parameter int unsigned WD_W    = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic                      sel,
  input  logic [WD_W-1:0]           wdata,
  output logic [2*PSC_W-1:0]        psc_vals,
  output logic [NUM_CH*LOG_W-1:0]   log_ratios,
  output logic                      restart
);
  logic [PSC_W-1:0]        psc_lo_q, psc_lo_d;
  logic [PSC_W-1:0]        psc_hi_q, psc_hi_d;
  logic [NUM_CH*SEL_W-1:0] div_q, div_d;
  logic                    wr_psc, wr_div;

  assign wr_psc  = we && (cfg_word_e'(sel) == CFG_WORD_PSC);
  assign wr_div  = we && (cfg_word_e'(sel) == CFG_WORD_DIV);
  assign restart = we;

  always_comb begin
    psc_lo_d = psc_lo_q;
    psc_hi_d = psc_hi_q;
    div_d    = div_q;
    if (wr_psc) begin
      psc_lo_d = wdata[PSC_W-1:0];
      psc_hi_d = wdata[2*PSC_W-1:PSC_W];
    end
    if (wr_div) begin
      div_d = wdata[NUM_CH*SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_lo_q <= PSC_W'(1);
      psc_hi_q <= PSC_W'(1);
      div_q    <= '0;
    end else begin
      psc_lo_q <= psc_lo_d;
      psc_hi_q <= psc_hi_d;
      div_q    <= div_d;
    end
  end

  assign psc_vals = {psc_hi_q, psc_lo_q};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sat
    logic [SEL_W-1:0] field;
    assign field = div_q[c*SEL_W +: SEL_W];
    assign log_ratios[c*LOG_W +: LOG_W] =
      (field > SEL_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : LOG_W'(field);

    AST_SEL_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
      log_ratios[c*LOG_W +: LOG_W] <= LOG_W'(MAX_LOG)); // R6
  end

  AST_RESET_PSC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_psc |=> $stable(psc_vals)); // R7
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PSC_W-1:0] limit,
  output logic             pulse
);
  logic [PSC_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == limit);
  assign pulse  = at_end;

  always_comb begin
    cnt_d = cnt_q + PSC_W'(1);
    if (restart || at_end) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PSC_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R7
  AST_PSC_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R2
  AST_PSC_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !restart && limit != '0) |=> !pulse); // R9
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned MAX_LOG = 4,
  parameter int unsigned LOG_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [LOG_W-1:0] log_ratio,
  output logic             tick
);
  localparam int unsigned CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] terminal;
  logic             last;
  logic             tick_q, tick_d;

  assign terminal = CNT_W'((32'd1 << log_ratio) - 32'd1);
  assign last     = (cnt_q == terminal);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d  = last ? '0 : cnt_q + CNT_W'(1);
      tick_d = last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  AST_TICK_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(step)); // R2
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick_q); // R7
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && log_ratio != '0) |=> !tick_q); // R8
endmodule

// File: rtl/dual_psc_tick_gen.sv
module dual_psc_tick_gen #(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned LO_GROUP = 2,
  parameter int unsigned PSC_W    = 8,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned MAX_LOG  = 4,
  parameter int unsigned WD_W     = ((2*PSC_W) > (NUM_CH*SEL_W)) ? (2*PSC_W) : (NUM_CH*SEL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [WD_W-1:0]   cfg_wdata,
  output logic [NUM_CH-1:0] tick
);
  localparam int unsigned LOG_W  = $clog2(MAX_LOG + 1);
  localparam int unsigned NUM_PS = 2;

  logic [2*PSC_W-1:0]      psc_vals;
  logic [NUM_CH*LOG_W-1:0] log_ratios;
  logic                    restart;
  logic [NUM_PS-1:0]       psc_pulse;

  tick_cfg_regs #(
    .NUM_CH(NUM_CH), .PSC_W(PSC_W), .SEL_W(SEL_W),
    .MAX_LOG(MAX_LOG), .LOG_W(LOG_W), .WD_W(WD_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .psc_vals(psc_vals), .log_ratios(log_ratios), .restart(restart)
  );

  for (genvar p = 0; p < NUM_PS; p++) begin : g_psc
    tick_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .limit(psc_vals[p*PSC_W +: PSC_W]), .pulse(psc_pulse[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic step;
    if (c < LO_GROUP) begin : g_lo
      assign step = psc_pulse[0];
    end else begin : g_hi
      assign step = psc_pulse[1];
    end
    tick_divider #(.MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
      .log_ratio(log_ratios[c*LOG_W +: LOG_W]), .tick(tick[c])
    );
  end

  AST_WRITE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (tick == '0)); // R7
endmodule

// File: tb/tb_dual_psc_tick_gen.sv
module tb_dual_psc_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_sel;
  logic [19:0] cfg_wdata;
  logic [4:0]  tick;

  int n_checks = 0;
  int n_bad    = 0;
  int cyc      = 0;
  int edges    = 0;
  bit finished = 0;
  logic [19:0] m_psc;
  logic [19:0] m_div;

  always #2 clk = ~clk;

  dual_psc_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tick(tick)
  );

  function automatic int period(input int c);
    int p, s;
    p = (c < 2) ? int'(m_psc[7:0]) : int'(m_psc[15:8]);
    s = int'(m_div[4*c +: 4]);
    if (s > 4) s = 4;
    return (p + 1) << s;
  endfunction

  function automatic logic [4:0] expect_tick();
    logic [4:0] e;
    for (int c = 0; c < 5; c++) begin
      e[c] = (cyc > 0) && ((cyc % period(c)) == 0);
    end
    return e;
  endfunction

  task automatic check(input string tag);
    logic [4:0] e;
    e = expect_tick();
    n_checks++;
    if (tick !== e) begin
      n_bad++;
      $display("FAIL %s: tick=%b expected=%b cycle=%0d", tag, tick, e, cyc);
    end
  endtask

  task automatic one_cycle(input bit we, input bit sel, input logic [19:0] d,
                           input string tag);
    cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    if (we) begin
      cyc = 0;
      if (sel) m_div = d; else m_psc = d;
    end else begin
      cyc++;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) one_cycle(1'b0, 1'b0, 20'h0, tag);
  endtask

  always @(posedge clk) begin
    edges++;
    if (edges > 150000 && !finished) begin
      finished = 1;
      n_bad++;
      n_checks++;
      $display("FAIL watchdog: cycles=%0d expected=<150000", edges);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    m_psc = 20'h00101; m_div = 20'h0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    check("R1");
    idle(20, "R1");

    // R9 / R8: zero prescalers, divide by one -> tick every cycle
    one_cycle(1'b1, 1'b0, 20'h00000, "R7");
    idle(10, "R9");
    one_cycle(1'b1, 1'b1, 20'h01010, "R8");
    idle(20, "R8");

    // R3, R4: distinct prescalers per group
    one_cycle(1'b1, 1'b1, 20'h00000, "R7");
    one_cycle(1'b1, 1'b0, 20'h00502, "R3");
    idle(40, "R4");

    // R5: distinct fields per channel
    one_cycle(1'b1, 1'b1, 20'h43210, "R5");
    idle(200, "R5");

    // R6: selects above 4 saturate to divide by 16
    one_cycle(1'b1, 1'b0, 20'h00100, "R7");
    one_cycle(1'b1, 1'b1, 20'hF9857, "R6");
    idle(100, "R6");

    // R7: mid-interval rewrite with the same value restarts timing
    one_cycle(1'b1, 1'b0, 20'h00301, "R7");
    one_cycle(1'b1, 1'b1, 20'h00000, "R7");
    idle(5, "R2");
    one_cycle(1'b1, 1'b1, 20'h00000, "R7");
    idle(12, "R7");

    // random configurations with small prescalers
    for (int r = 0; r < 40; r++) begin
      logic [19:0] a, b;
      int len;
      a = $urandom() & 20'h00707;
      b = $urandom();
      one_cycle(1'b1, 1'b0, a, "R2");
      one_cycle(1'b1, 1'b1, b, "R2");
      len = 1 + ($urandom() % 150);
      idle(len, "R2");
      if (($urandom() % 3) == 0) begin
        one_cycle(1'b1, $urandom() % 2 == 0, ($urandom() % 2 == 0) ? m_psc : m_div, "R7");
        idle(40, "R7");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule